// File: doc/BRIEF.md
# Narrow Floating-Point Multiplier

This block multiplies two operands held in a compact 18-bit floating-point word and returns their product in the same word. A word packs a sign bit at the top, then an 8-bit exponent, then a 9-bit mantissa: `{sign, exp[7:0], mant[8:0]}`. The value it stands for is (-1)^sign × 0.mant × 2^(exp-128). The exponent is offset binary with a bias of 128. The mantissa is a binary fraction whose top bit is always 1 for a nonzero number, so it lies in [0.5, 1). The value zero is any word whose mantissa top bit is 0.

The multiplier is purely combinational. It forms one 9×9 unsigned mantissa product. When that product falls below one half, it normalizes the product with a single left shift. It drops the low product bits without rounding. Results that underflow are flushed to the all-zero word. The block has no special values and no overflow detection, which suits realtime filter datapaths where memory width and multiplier count matter more than IEEE conformance.

Top module: `nfmul_core`

## Requirements
- R1: For a nonzero result, the output sign bit (bit 17) is the XOR of the two operand sign bits.
- R2: When bit 17 of the 18-bit mantissa product mantA×mantB is 1, the output mantissa is product bits [17:9] and the output exponent is expA+expB-128.
- R3: When bit 17 of the mantissa product is 0, the product is shifted left by one. The output mantissa is then the original product bits [16:8], and the output exponent is expA+expB-129.
- R4: When expA+expB, taken as an unsigned sum without wrap, is less than 129, the output is the all-zero word 18'h00000. A sum of exactly 129 is not an underflow.
- R5: When either operand has a mantissa top bit (bit 8) of 0, the output is 18'h00000, whatever the signs and exponents of the operands.
- R6: Product bits below the 9 kept mantissa bits are discarded without rounding (for example, 0x1FF × 0x1FF gives mantissa 0x1FE).
- R7: A result exponent above 255 is not detected. The exponent field carries the low 8 bits of the result exponent.
- R8: Every output word is either 18'h00000 or has mantissa bit 8 set.
- R9: The output follows the inputs with no clock. A new operand pair gives its product without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 18 | First operand {sign, exp[7:0], mant[8:0]} |
| opB | input | 18 | Second operand, same format |
| product | output | 18 | opA × opB, same format |

## Verification
The checker continuously confirms four properties of the output. Nonzero results carry the XOR of the input signs. Underflowing exponent sums and zero operands always give the zero word. Nonzero outputs are normalized. The output exponent always sits 128 or 129 below the operand exponent sum. Only the bench scenarios can show which of the two exponent offsets is chosen, the exact truncated mantissa bits, the 129 boundary of the underflow test, and the exponent wrap. The bench also shows that a result is present with no clock edge in between.

// File: rtl/nfmul_pkg.sv
package nfmul_pkg;

  // Strobes from the control decision logic to the datapath.
  typedef struct packed {
    logic forceZero;   // emit the all-zero word
    logic shiftOne;    // normalize the product by one left shift
  } mulStrobe_t;

endpackage

// File: rtl/nfmul_control.sv
module nfmul_control
  import nfmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int BIAS  = 128
) (
  input  logic             normBit,
  input  logic [EXP_W+1:0] expSum,
  input  logic             mantMsbA,
  input  logic             mantMsbB,
  output mulStrobe_t       strobe
);

  localparam int SUM_W = EXP_W + 2;
  localparam logic [SUM_W-1:0] UNDER_LIMIT = SUM_W'(BIAS + 1);

  logic underflow;
  logic zeroOperand;

  always_comb begin
    // The sum is kept two bits wider than an exponent, so it never wraps here.
    underflow   = expSum < UNDER_LIMIT;
    zeroOperand = !mantMsbA || !mantMsbB;
    strobe.forceZero = underflow || zeroOperand;
    strobe.shiftOne  = !normBit;
  end

endmodule

// File: rtl/nfmul_datapath.sv
module nfmul_datapath
  import nfmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 9,
  parameter int BIAS  = 128
) (
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  input  mulStrobe_t           strobe,
  output logic                 normBit,
  output logic [EXP_W+1:0]     expSum,
  output logic                 mantMsbA,
  output logic                 mantMsbB,
  output logic [EXP_W+MAN_W:0] result
);

  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int PROD_W = 2 * MAN_W;
  localparam int SUM_W  = EXP_W + 2;
  localparam logic [SUM_W-1:0] BIAS_V = SUM_W'(BIAS);

  logic              signA, signB;
  logic [EXP_W-1:0]  expA, expB;
  logic [MAN_W-1:0]  mantA, mantB;
  logic [PROD_W-1:0] rawProd;
  logic [PROD_W-1:0] normProd;
  logic [SUM_W-1:0]  expAdj;
  logic [MAN_W-1:0]  mantOut;

  always_comb begin
    signA = opA[WORD_W-1];
    signB = opB[WORD_W-1];
    expA  = opA[WORD_W-2 -: EXP_W];
    expB  = opB[WORD_W-2 -: EXP_W];
    mantA = opA[MAN_W-1:0];
    mantB = opB[MAN_W-1:0];
    mantMsbA = mantA[MAN_W-1];
    mantMsbB = mantB[MAN_W-1];

    rawProd = {{MAN_W{1'b0}}, mantA} * {{MAN_W{1'b0}}, mantB};
    normBit = rawProd[PROD_W-1];
    expSum  = {2'b00, expA} + {2'b00, expB};

    normProd = strobe.shiftOne ? (rawProd << 1) : rawProd;
    mantOut  = normProd[PROD_W-1 -: MAN_W];
    expAdj   = expSum - BIAS_V - {{(SUM_W-1){1'b0}}, strobe.shiftOne};

    if (strobe.forceZero)
      result = '0;
    else
      result = {signA ^ signB, expAdj[EXP_W-1:0], mantOut};
  end

endmodule

// File: rtl/nfmul_core.sv
module nfmul_core
  import nfmul_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 9,
  parameter int BIAS  = 128
) (
  input  logic [EXP_W+MAN_W:0] opA,
  input  logic [EXP_W+MAN_W:0] opB,
  output logic [EXP_W+MAN_W:0] product
);

  mulStrobe_t       strobe;
  logic             normBit;
  logic [EXP_W+1:0] expSum;
  logic             mantMsbA;
  logic             mantMsbB;

  nfmul_control #(.EXP_W(EXP_W), .BIAS(BIAS)) u_ctrl (
    .normBit (normBit),
    .expSum  (expSum),
    .mantMsbA(mantMsbA),
    .mantMsbB(mantMsbB),
    .strobe  (strobe)
  );

  nfmul_datapath #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .normBit (normBit),
    .expSum  (expSum),
    .mantMsbA(mantMsbA),
    .mantMsbB(mantMsbB),
    .result  (product)
  );

endmodule

// File: rtl/nfmul_core_chk.sv
module nfmul_core_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 9,
  parameter int BIAS  = 128
) (
  input logic [EXP_W+MAN_W:0] opA,
  input logic [EXP_W+MAN_W:0] opB,
  input logic [EXP_W+MAN_W:0] product
);

  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int SUM_W  = EXP_W + 2;

  logic [SUM_W-1:0] sumChk;
  logic [SUM_W-1:0] offHi, offLo;
  logic [EXP_W-1:0] outExp;

  always_comb begin
    sumChk = {2'b00, opA[WORD_W-2 -: EXP_W]} + {2'b00, opB[WORD_W-2 -: EXP_W]};
    offHi  = sumChk - SUM_W'(BIAS);
    offLo  = sumChk - SUM_W'(BIAS + 1);
    outExp = product[WORD_W-2 -: EXP_W];

    if (product != '0)
      assert_sign_xor_R1: assert (product[WORD_W-1] == (opA[WORD_W-1] ^ opB[WORD_W-1]))
        else $error("sign of nonzero product is not the XOR of input signs");

    // Covers R2 and R3: the exponent is one of the two allowed offsets.
    if (product != '0)
      assert_exp_offset_R2: assert (outExp == offHi[EXP_W-1:0] || outExp == offLo[EXP_W-1:0])
        else $error("product exponent not 128 or 129 below the exponent sum");

    if (sumChk < SUM_W'(BIAS + 1))
      assert_underflow_zero_R4: assert (product == '0)
        else $error("underflowing exponent sum gave a nonzero product");

    if (!opA[MAN_W-1] || !opB[MAN_W-1])
      assert_zero_operand_R5: assert (product == '0)
        else $error("zero operand gave a nonzero product");

    assert_normalized_R8: assert (product == '0 || product[MAN_W-1])
      else $error("nonzero product is not normalized");
  end

endmodule

bind nfmul_core nfmul_core_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .BIAS(BIAS)) u_chk (
  .opA    (opA),
  .opB    (opB),
  .product(product)
);

// File: tb/nfmul_core_test.sv
module nfmul_core_test;

  typedef struct {
    logic [17:0] a;
    logic [17:0] b;
    logic [17:0] want;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [17:0] opA = '0;
  logic [17:0] opB = '0;
  logic [17:0] product;

  int checks = 0;
  int fails  = 0;
  bit driverDone = 0;
  item_t sb[$];

  nfmul_core uut (.opA(opA), .opB(opB), .product(product));

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [17:0] mk(input logic s, input logic [7:0] e, input logic [8:0] m);
    return {s, e, m};
  endfunction

  // Reference from the requirements: value = 0.m * 2^(e-128).
  function automatic logic [17:0] model(input logic [17:0] a, input logic [17:0] b);
    logic [17:0] p;
    int unsigned sum;
    int unsigned ex;
    logic [8:0] m;
    p   = 18'(a[8:0]) * 18'(b[8:0]);
    sum = int'(a[16:9]) + int'(b[16:9]);
    if (!a[8] || !b[8] || sum < 129) return 18'h0;
    if (p[17]) begin m = p[17:9]; ex = sum - 128; end
    else       begin m = p[16:8]; ex = sum - 129; end
    return {a[17] ^ b[17], 8'(ex), m};
  endfunction

  task automatic check(input string tag, input logic [17:0] got, input logic [17:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: product=%h expected=%h", tag, got, want);
    end
  endtask

  task automatic drive(input logic [17:0] a, input logic [17:0] b,
                       input logic [17:0] want, input string tag);
    item_t it;
    @(posedge clk);
    opA = a;
    opB = b;
    it.a = a; it.b = b; it.want = want; it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compares away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, product, it.want);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: product=%h expected=done", product);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("reset R5 zero inputs", product, 18'h0);
    rst = 1'b0;

    // R3: 0.5*2^0 squared = 0.25 -> {0,0x7F,0x100}
    drive(mk(0, 8'd128, 9'h100), mk(0, 8'd128, 9'h100), 18'h0FF00, "R3 half squared");
    // R1 R3: -25 * 1.0 = -25
    drive(mk(1, 8'd133, 9'h190), mk(0, 8'd129, 9'h100), 18'h30B90, "R1 R3 neg25 times one");
    // R2: 0.75 * 0.75 = 0.5625 -> product 0x24000, bit17 set, mant 0x120, exp 128
    drive(mk(1, 8'd128, 9'h180), mk(1, 8'd128, 9'h180), mk(0, 8'd128, 9'h120), "R2 R1 neg times neg");
    // R6: 0x1FF*0x1FF = 0x3FC01 -> mant 0x1FE, exp 130-128=2
    drive(mk(0, 8'd65, 9'h1FF), mk(1, 8'd65, 9'h1FF), mk(1, 8'd2, 9'h1FE), "R6 truncation");
    // R4 boundary: sum 128 with normalized product -> zero
    drive(mk(0, 8'd64, 9'h1FF), mk(0, 8'd64, 9'h1FF), 18'h0, "R4 sum 128 underflow");
    // R4 boundary: sum 129 is kept
    drive(mk(0, 8'd64, 9'h1FF), mk(0, 8'd65, 9'h1FF), mk(0, 8'd1, 9'h1FE), "R4 sum 129 kept");
    // R4: sum 129 with shift gives exponent 0 but is not underflow
    drive(mk(1, 8'd0, 9'h100), mk(0, 8'd129, 9'h100), mk(1, 8'd0, 9'h100), "R4 R3 exp zero kept");
    // R5: zero operand with sign and big exponent
    drive(mk(1, 8'd200, 9'h0FF), mk(1, 8'd200, 9'h1FF), 18'h0, "R5 zero A");
    drive(mk(0, 8'd200, 9'h1AB), mk(1, 8'd255, 9'h000), 18'h0, "R5 zero B");
    // R7: exponent wrap 255+255-128 = 382 -> 126
    drive(mk(0, 8'd255, 9'h180), mk(0, 8'd255, 9'h180), mk(0, 8'd126, 9'h120), "R7 exponent wrap");

    // Sweep of mixed patterns
    for (int i = 1; i <= 300; i++) begin
      logic [17:0] a, b;
      a = mk(i[0], 8'((i * 37) & 255), (i % 23 == 0) ? 9'h0 : (9'h100 | 9'((i * 53) & 255)));
      b = mk(i[1], 8'((i * 91 + 60) & 255), 9'h100 | 9'((i * 29 + 7) & 255));
      drive(a, b, model(a, b), "R2 R3 R8 sweep");
    end

    // R9: result with no clock edge in between
    @(negedge clk);
    #2;
    opA = mk(0, 8'd130, 9'h1C0);
    opB = mk(1, 8'd127, 9'h140);
    #1;
    check("R9 no clock", product, model(mk(0, 8'd130, 9'h1C0), mk(1, 8'd127, 9'h140)));
    opA = mk(0, 8'd140, 9'h100);
    #1;
    check("R9 no clock second", product, model(mk(0, 8'd140, 9'h100), mk(1, 8'd127, 9'h140)));

    repeat (3) @(posedge clk);
    driverDone = 1;
    if (sb.size() != 0) begin
      fails++;
      checks++;
      $display("FAIL scoreboard: left=%0d expected=0", sb.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule